// File: doc/BRIEF.md
# Per-Area External Bus Timing Controller

This block times static-memory bus cycles for a processor whose external address space is divided into numbered areas. A small register bank holds, for each group of areas, the width of the attached device, how many wait cycles to insert, and how long the data bus must stay quiet after a read before the next cycle may start. The groups are areas 4–5, area 6 alone, and then 7–8, 9–10, 11–12, 13–14, 15–16 and 17–18. For each request the block receives the area number, the direction, a device class and an active-low external wait line. It then drives an active-low read or write strobe, reports the device width, and raises a one-tick completion flag.

The block runs on a clock at twice the bus rate, so one bus cycle is two ticks and turnaround gaps are counted in half bus cycles. A requester raises `req` with the request fields and holds them until `done`. In the tick where `done` is high it may drop `req` or present the next request. A request that arrives during a turnaround gap waits until the gap has ended.

There are two resets. A cold reset restores the default settings. A hot reset only returns the sequencer to idle and leaves every programmed setting as it was.

Top module: `ext_bus_timing`

## Requirements
- R1: While `cold_rst_n` is low, `rd_n` and `wr_n` are 1 and `done` and `turn_gap` are 0. After a cold reset every group has size 0 (16-bit), turnaround 3 and wait 7. Registers 0 and 5 read 0x3737 and registers 1–4 read 0x0037.
- R2: A pulse on `hot_rst_n` drives both strobes inactive and clears `done` and `turn_gap` at once. It leaves every register value unchanged, and the next request is served normally.
- R3: There are six 16-bit registers, indexed 0–5. The lower half of a register holds size at bit 6, turnaround at bits 5:4 and wait at bits 2:0. The upper half holds the same fields at bits 14, 13:12 and 10:8. The group placement is:
  - register 0: lower half for areas 4–5, upper half for area 6 (area 6 has no size bit);
  - registers 1–4: lower half for areas 7–8, 9–10, 11–12 and 13–14 in that order;
  - register 5: lower half for areas 15–16, upper half for areas 17–18.
  All other bits read 0 and ignore writes. Area numbers outside 4–18 use the settings of areas 4–5.
- R4: While a strobe is active, `bus_8bit` equals the size bit of the area's group (1 = 8-bit, 0 = 16-bit). For area 6 it is 1 when `req_a6_upper` is 0 and 0 when it is 1, whatever any register holds.
- R5: `req_class` uses 0 = SRAM, 1 = DRAM, 2 = burst ROM, and 3 is handled as SRAM. With group wait W, an SRAM read holds its strobe for 2·(1+W) ticks. An SRAM write holds it for 2·(1+max(W,1)) ticks.
- R6: For SRAM cycles and burst-ROM writes, `ext_wait_n` is sampled when the programmed length runs out. Each low sample adds one bus cycle (2 ticks), and the cycle ends at the first high sample.
- R7: DRAM reads hold the strobe for 2 ticks and DRAM writes for 4 ticks, whatever the wait field or `ext_wait_n` says.
- R8: A burst-ROM read with `req_burst_next` = 0 lasts 2·(1+W) ticks. One with `req_burst_next` = 1 lasts 2 ticks. Neither is stretched by `ext_wait_n`. Burst-ROM writes time like SRAM writes.
- R9: `rd_n` goes low only for reads and `wr_n` only for writes, never both at once. `done` is high for exactly the one tick after the strobe ends.
- R10: After a read, `turn_gap` is high for 2·T+1 ticks following `done`, where T is the group's turnaround field, and no strobe starts during that time. After a write there is no gap. A request held through the gap is then served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| cold_rst_n | input | 1 | Active-low cold reset: settings to defaults, sequencer idle |
| hot_rst_n | input | 1 | Active-low hot reset: sequencer idle, settings kept |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register index 0–5 |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| req | input | 1 | Bus cycle request, held until `done` |
| req_area | input | 5 | Area number of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_class | input | 2 | Device class (see R5) |
| req_burst_next | input | 1 | Burst-ROM read is a later beat of a burst |
| req_a6_upper | input | 1 | Area 6 address falls in its upper half |
| ext_wait_n | input | 1 | Active-low external wait |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| bus_8bit | output | 1 | Width of the device in the current cycle |
| done | output | 1 | One-tick cycle completion |
| turn_gap | output | 1 | Read turnaround gap in progress |

## Verification
A wrong wait or class decode shows up in the length of the very next strobe, in ticks, so every area and class combination is timed against an arithmetic model under two register images that together use every wait value. A wrong group lookup or field position shows up the same way, and also in `bus_8bit` on the first strobe tick and in register readback in the same tick. A lost turnaround count appears as a wrong number of quiet ticks between a read's `done` and the next strobe, within at most eight ticks. A lost setting after a hot reset appears in the readback straight after that reset.

// File: rtl/ebt_pkg.sv
package ebt_pkg;

   typedef enum logic [1:0] {
      CLS_SRAM = 2'd0,
      CLS_DRAM = 2'd1,
      CLS_BROM = 2'd2,
      CLS_RSVD = 2'd3
   } dev_class_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACTIVE,
      ST_DONE,
      ST_GAP
   } seq_state_e;

   // setting groups: 0 = areas 4-5, 1 = area 6, 2..6 = pairs 7-8 .. 15-16, 7 = 17-18
   localparam int GRP_CNT = 8;
   localparam int REG_CNT = 6;

   function automatic int grp_reg(input int g);
      if (g <= 1) return 0;
      if (g == 7) return 5;
      return g - 1;
   endfunction

   function automatic bit grp_upper(input int g);
      return (g == 1) || (g == 7);
   endfunction

   function automatic bit grp_has_size(input int g);
      return g != 1;
   endfunction

   function automatic int area_group(input int a);
      if (a == 6) return 1;
      if (a >= 7 && a <= 18) return (a - 7) / 2 + 2;
      return 0;
   endfunction

endpackage

// File: rtl/ebt_cfg_regs.sv
module ebt_cfg_regs
   import ebt_pkg::*;
#(
   parameter int WT_W   = 3,
   parameter int DF_W   = 2,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic                              clk,
   input  logic                              cold_rst_n,
   input  logic                              cfg_we,
   input  logic [ADDR_W-1:0]                 cfg_addr,
   input  logic [DATA_W-1:0]                 cfg_wdata,
   output logic [DATA_W-1:0]                 cfg_rdata,
   output logic [GRP_CNT-1:0][WT_W-1:0]      wt_o,
   output logic [GRP_CNT-1:0][DF_W-1:0]      df_o,
   output logic [GRP_CNT-1:0]                sz_o
);

   localparam int HALF  = DATA_W / 2;
   localparam int LO_WT = 0;
   localparam int LO_DF = 4;
   localparam int LO_SZ = 6;

   if (LO_WT + WT_W > LO_DF) begin : g_bad_wt
      $error("wait field overlaps turnaround field");
   end
   if (LO_DF + DF_W > LO_SZ) begin : g_bad_df
      $error("turnaround field overlaps size bit");
   end
   if (LO_SZ >= HALF) begin : g_bad_half
      $error("register half too narrow for the field set");
   end
   if ((1 << ADDR_W) < REG_CNT) begin : g_bad_addr
      $error("register index too narrow");
   end

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^cfg_wdata;

   for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
      localparam int RIDX = grp_reg(g);
      localparam int OFF  = grp_upper(g) ? HALF : 0;
      logic            hit;
      logic [WT_W-1:0] wt_q;
      logic [DF_W-1:0] df_q;

      assign hit = cfg_we && (cfg_addr == ADDR_W'(RIDX));

      always_ff @(posedge clk or negedge cold_rst_n) begin
         if (!cold_rst_n) begin
            wt_q <= '1;
            df_q <= '1;
         end else if (hit) begin
            wt_q <= cfg_wdata[OFF+LO_WT +: WT_W];
            df_q <= cfg_wdata[OFF+LO_DF +: DF_W];
         end
      end
      assign wt_o[g] = wt_q;
      assign df_o[g] = df_q;

      if (grp_has_size(g)) begin : g_sz
         logic sz_q;
         always_ff @(posedge clk or negedge cold_rst_n) begin
            if (!cold_rst_n) sz_q <= 1'b0;
            else if (hit)    sz_q <= cfg_wdata[OFF+LO_SZ];
         end
         assign sz_o[g] = sz_q;
      end else begin : g_nosz
         assign sz_o[g] = 1'b0;
      end
   end

   always_comb begin
      int off;
      cfg_rdata = '0;
      for (int g = 0; g < GRP_CNT; g++) begin
         off = grp_upper(g) ? HALF : 0;
         if (cfg_addr == ADDR_W'(grp_reg(g))) begin
            cfg_rdata = cfg_rdata
                      | (DATA_W'(wt_o[g]) << (off + LO_WT))
                      | (DATA_W'(df_o[g]) << (off + LO_DF))
                      | (DATA_W'(sz_o[g]) << (off + LO_SZ));
         end
      end
   end

   // R3: settings only move on a write
   assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !cfg_we |=> ($stable(wt_o) && $stable(df_o) && $stable(sz_o)));

endmodule

// File: rtl/ebt_area_sel.sv
module ebt_area_sel
   import ebt_pkg::*;
#(
   parameter int AREA_W = 5,
   parameter int WT_W   = 3,
   parameter int DF_W   = 2
) (
   input  logic [AREA_W-1:0]            area,
   input  logic                         a6_upper,
   input  logic [GRP_CNT-1:0][WT_W-1:0] wt_i,
   input  logic [GRP_CNT-1:0][DF_W-1:0] df_i,
   input  logic [GRP_CNT-1:0]           sz_i,
   output logic [WT_W-1:0]              sel_wt,
   output logic [DF_W-1:0]              sel_df,
   output logic                         sel_w8
);

   localparam int GRP_IW = $clog2(GRP_CNT);

   if (AREA_W < 5) begin : g_bad_area
      $error("area number too narrow to name every area");
   end

   logic [GRP_IW-1:0] grp;

   assign grp    = GRP_IW'(area_group(int'(area)));
   assign sel_wt = wt_i[grp];
   assign sel_df = df_i[grp];
   assign sel_w8 = (grp == GRP_IW'(1)) ? !a6_upper : sz_i[grp];

endmodule

// File: rtl/ebt_seq.sv
module ebt_seq
   import ebt_pkg::*;
#(
   parameter int WT_W = 3,
   parameter int DF_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            req_write,
   input  logic [1:0]      req_class,
   input  logic            req_burst_next,
   input  logic            ext_wait_n,
   input  logic [WT_W-1:0] sel_wt,
   input  logic [DF_W-1:0] sel_df,
   input  logic            sel_w8,
   output logic            rd_n,
   output logic            wr_n,
   output logic            bus_8bit,
   output logic            done,
   output logic            turn_gap
);

   localparam int CNT_W = WT_W + 2;
   localparam int GAP_W = DF_W + 1;

   seq_state_e      st;
   logic [CNT_W-1:0] cnt;
   logic [GAP_W-1:0] gap;
   logic             is_rd;
   logic             wen_q;
   logic             w8_q;
   logic [DF_W-1:0]  df_q;

   logic [WT_W-1:0]  wr_floor;
   logic [WT_W-1:0]  waits;
   logic             wen;
   logic [CNT_W-1:0] load;

   always_comb begin
      wr_floor = (sel_wt == '0) ? WT_W'(1) : sel_wt;
      case (dev_class_e'(req_class))
         CLS_DRAM: begin
            waits = req_write ? WT_W'(1) : '0;
            wen   = 1'b0;
         end
         CLS_BROM: begin
            waits = req_write ? wr_floor : (req_burst_next ? '0 : sel_wt);
            wen   = req_write;
         end
         default: begin
            waits = req_write ? wr_floor : sel_wt;
            wen   = 1'b1;
         end
      endcase
      load = CNT_W'({waits, 1'b1});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         gap   <= '0;
         is_rd <= 1'b0;
         wen_q <= 1'b0;
         w8_q  <= 1'b0;
         df_q  <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req) begin
               st    <= ST_ACTIVE;
               cnt   <= load;
               is_rd <= !req_write;
               wen_q <= wen;
               w8_q  <= sel_w8;
               df_q  <= sel_df;
            end
            ST_ACTIVE: begin
               if (cnt != '0)                  cnt <= cnt - CNT_W'(1);
               else if (wen_q && !ext_wait_n)  cnt <= CNT_W'(1);
               else                            st  <= ST_DONE;
            end
            ST_DONE: begin
               if (is_rd) begin
                  st  <= ST_GAP;
                  gap <= {df_q, 1'b0};
               end else begin
                  st  <= ST_IDLE;
               end
            end
            default: begin
               if (gap == '0) st  <= ST_IDLE;
               else           gap <= gap - GAP_W'(1);
            end
         endcase
      end
   end

   assign rd_n     = !((st == ST_ACTIVE) && is_rd);
   assign wr_n     = !((st == ST_ACTIVE) && !is_rd);
   assign done     = (st == ST_DONE);
   assign turn_gap = (st == ST_GAP);
   assign bus_8bit = w8_q;

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_gap_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_rd) |=> turn_gap);

   assert_no_gap_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !is_rd) |=> (!turn_gap && rd_n && wr_n));

   assert_ext_wait_extends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_ACTIVE) && (cnt == '0) && wen_q && !ext_wait_n) |=> (st == ST_ACTIVE));

   assert_no_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_ACTIVE) && (cnt == '0) && !wen_q) |=> done);

   assert_burst_beat_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_IDLE) && req && !req_write && req_burst_next
       && (dev_class_e'(req_class) == CLS_BROM)) |-> ##3 done);

endmodule

// File: rtl/ext_bus_timing.sv
module ext_bus_timing
   import ebt_pkg::*;
#(
   parameter int AREA_W = 5,
   parameter int WT_W   = 3,
   parameter int DF_W   = 2,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              hot_rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              req,
   input  logic [AREA_W-1:0] req_area,
   input  logic              req_write,
   input  logic [1:0]        req_class,
   input  logic              req_burst_next,
   input  logic              req_a6_upper,
   input  logic              ext_wait_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic              bus_8bit,
   output logic              done,
   output logic              turn_gap
);

   logic                         seq_rst_n;
   logic [GRP_CNT-1:0][WT_W-1:0] grp_wt;
   logic [GRP_CNT-1:0][DF_W-1:0] grp_df;
   logic [GRP_CNT-1:0]           grp_sz;
   logic [WT_W-1:0]              sel_wt;
   logic [DF_W-1:0]              sel_df;
   logic                         sel_w8;

   assign seq_rst_n = cold_rst_n & hot_rst_n;

   ebt_cfg_regs #(
      .WT_W(WT_W), .DF_W(DF_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .cold_rst_n(cold_rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .wt_o(grp_wt), .df_o(grp_df), .sz_o(grp_sz)
   );

   ebt_area_sel #(
      .AREA_W(AREA_W), .WT_W(WT_W), .DF_W(DF_W)
   ) u_sel (
      .area(req_area), .a6_upper(req_a6_upper),
      .wt_i(grp_wt), .df_i(grp_df), .sz_i(grp_sz),
      .sel_wt(sel_wt), .sel_df(sel_df), .sel_w8(sel_w8)
   );

   ebt_seq #(
      .WT_W(WT_W), .DF_W(DF_W)
   ) u_seq (
      .clk(clk), .rst_n(seq_rst_n),
      .req(req), .req_write(req_write), .req_class(req_class),
      .req_burst_next(req_burst_next), .ext_wait_n(ext_wait_n),
      .sel_wt(sel_wt), .sel_df(sel_df), .sel_w8(sel_w8),
      .rd_n(rd_n), .wr_n(wr_n), .bus_8bit(bus_8bit), .done(done), .turn_gap(turn_gap)
   );

   // R2: a hot reset drops any strobe at once
   assert_hot_reset_idle_R2: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !hot_rst_n |-> (rd_n && wr_n && !done));

endmodule

// File: tb/test_ext_bus_timing.sv
module test_ext_bus_timing;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        cold_rst_n = 1'b0;
   logic        hot_rst_n = 1'b1;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        req = 1'b0;
   logic [4:0]  req_area = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_class = '0;
   logic        req_burst_next = 1'b0;
   logic        req_a6_upper = 1'b0;
   logic        ext_wait_n = 1'b1;
   logic        rd_n, wr_n, bus_8bit, done, turn_gap;

   int checks = 0;
   int failures = 0;
   int bwt [8];
   int bdf [8];
   int bsz [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_bus_timing i_ext_bus_timing (
      .clk(clk), .cold_rst_n(cold_rst_n), .hot_rst_n(hot_rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req(req), .req_area(req_area), .req_write(req_write), .req_class(req_class),
      .req_burst_next(req_burst_next), .req_a6_upper(req_a6_upper), .ext_wait_n(ext_wait_n),
      .rd_n(rd_n), .wr_n(wr_n), .bus_8bit(bus_8bit), .done(done), .turn_gap(turn_gap)
   );

   task automatic chk(input string rq, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", rq, got, exp);
      end
   endtask

   function automatic int exp_group(input int a);
      case (a)
         4, 5:   return 0;
         6:      return 1;
         7, 8:   return 2;
         9, 10:  return 3;
         11, 12: return 4;
         13, 14: return 5;
         15, 16: return 6;
         17, 18: return 7;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_ticks(input int w, input bit wr, input int cls, input bit nxt);
      int waits;
      int wmin;
      wmin = (w < 1) ? 1 : w;
      if (cls == 1)      waits = wr ? 1 : 0;
      else if (cls == 2) waits = wr ? wmin : (nxt ? 0 : w);
      else               waits = wr ? wmin : w;
      return 2 * (1 + waits);
   endfunction

   function automatic bit exp_honor(input int cls, input bit wr);
      if (cls == 1) return 1'b0;
      if (cls == 2) return wr;
      return 1'b1;
   endfunction

   function automatic int half_word(input int g, input bit with_sz);
      return (with_sz ? (bsz[g] << 6) : 0) | (bdf[g] << 4) | bwt[g];
   endfunction

   function automatic int exp_word(input int r);
      if (r == 0) return (half_word(1, 1'b0) << 8) | half_word(0, 1'b1);
      if (r == 5) return (half_word(7, 1'b1) << 8) | half_word(6, 1'b1);
      return half_word(r + 1, 1'b1);
   endfunction

   task automatic wr_reg(input int r, input int val);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = 3'(r);
      cfg_wdata = 16'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_chk(input int r, input string rq);
      @(negedge clk);
      cfg_addr = 3'(r);
      #1;
      chk(rq, int'(cfg_rdata), exp_word(r));
   endtask

   task automatic apply_cfg(input int p);
      for (int g = 0; g < 8; g++) begin
         bwt[g] = (g * 3 + 1 + p * 4) % 8;
         bdf[g] = (g + p) % 4;
         bsz[g] = (g + p) % 2;
      end
      // unused bits 15, 11, 7, 3 set; area 6 has no size bit; regs 1-4 have no upper half
      wr_reg(0, 16'h8888 | 16'h4000 | exp_word(0));
      for (int r = 1; r <= 4; r++) wr_reg(r, 16'h8888 | 16'h7700 | exp_word(r));
      wr_reg(5, 16'h8888 | exp_word(5));
   endtask

   task automatic run_cycle(input int area, input bit wr, input int cls, input bit nxt,
                            input bit a6u, input int k, input string rq);
      int g, n2, exp_cnt, rel_at, cnt, guard;
      bit honor, exp8;
      g = exp_group(area);
      n2 = exp_ticks(bwt[g], wr, cls, nxt);
      honor = exp_honor(cls, wr);
      exp_cnt = n2 + (honor ? 2 * k : 0);
      rel_at = honor ? n2 + 2 * k : -1;
      exp8 = (g == 1) ? !a6u : bsz[g][0];
      cnt = 0;
      guard = 0;
      @(negedge clk);
      req = 1'b1;
      req_area = 5'(area);
      req_write = wr;
      req_class = 2'(cls);
      req_burst_next = nxt;
      req_a6_upper = a6u;
      ext_wait_n = (k > 0) ? 1'b0 : 1'b1;
      forever begin
         @(negedge clk);
         guard++;
         if (!rd_n || !wr_n) begin
            cnt++;
            if (cnt == 1) begin
               chk({rq, " R9 strobe kind"}, int'({rd_n, wr_n}), wr ? 2 : 1);
               chk({rq, " R4 width"}, int'(bus_8bit), int'(exp8));
            end
         end
         if (cnt == rel_at) ext_wait_n = 1'b1;
         if (done || guard > 300) break;
      end
      req = 1'b0;
      ext_wait_n = 1'b1;
      chk({rq, " strobe ticks"}, cnt, exp_cnt);
      @(negedge clk);
      chk({rq, " R9 done one tick"}, int'(done), 0);
   endtask

   task automatic gap_pair(input int area, input bit first_wr);
      int g, hi, gp, guard;
      g = exp_group(area);
      hi = 0;
      gp = 0;
      guard = 0;
      @(negedge clk);
      req = 1'b1;
      req_area = 5'(area);
      req_write = first_wr;
      req_class = 2'd0;
      req_burst_next = 1'b0;
      ext_wait_n = 1'b1;
      do begin
         @(negedge clk);
         guard++;
      end while (!done && guard < 300);
      // request held straight through: the next cycle is a write to the same area
      req_write = 1'b1;
      forever begin
         @(negedge clk);
         guard++;
         if (!rd_n || !wr_n || guard > 300) break;
         hi++;
         if (turn_gap) gp++;
      end
      chk("R10 quiet ticks before next strobe", hi, first_wr ? 1 : 2 * bdf[g] + 2);
      chk("R10 turn_gap ticks", gp, first_wr ? 0 : 2 * bdf[g] + 1);
      do begin
         @(negedge clk);
         guard++;
      end while (!done && guard < 300);
      chk("R10 held request served", int'(done), 1);
      req = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_idle(input string rq);
      chk({rq, " rd_n"}, int'(rd_n), 1);
      chk({rq, " wr_n"}, int'(wr_n), 1);
      chk({rq, " done"}, int'(done), 0);
      chk({rq, " turn_gap"}, int'(turn_gap), 0);
   endtask

   task automatic set_defaults();
      for (int g = 0; g < 8; g++) begin
         bwt[g] = 7;
         bdf[g] = 3;
         bsz[g] = 0;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      set_defaults();
      repeat (3) @(negedge clk);
      check_idle("R1 in cold reset");
      for (int r = 0; r < 6; r++) rd_chk(r, "R1 default readback");
      @(negedge clk);
      cold_rst_n = 1'b1;
      run_cycle(4, 1'b0, 0, 1'b0, 1'b0, 0, "R1 default SRAM read R5");
      run_cycle(9, 1'b1, 0, 1'b0, 1'b0, 0, "R1 default SRAM write R5");

      for (int p = 0; p < 2; p++) begin
         apply_cfg(p);
         for (int r = 0; r < 6; r++) rd_chk(r, "R3 readback");
         for (int a = 2; a <= 19; a++) begin
            if (a == 3) continue;
            for (int op = 0; op < 8; op++) begin
               int cls, k;
               bit wr, nxt;
               string rq;
               case (op)
                  0: begin cls = 0; wr = 0; nxt = 0; rq = "R5 SRAM read";  end
                  1: begin cls = 0; wr = 1; nxt = 0; rq = "R5 SRAM write"; end
                  2: begin cls = 1; wr = 0; nxt = 0; rq = "R7 DRAM read";  end
                  3: begin cls = 1; wr = 1; nxt = 0; rq = "R7 DRAM write"; end
                  4: begin cls = 2; wr = 0; nxt = 0; rq = "R8 BROM first"; end
                  5: begin cls = 2; wr = 0; nxt = 1; rq = "R8 BROM beat";  end
                  6: begin cls = 2; wr = 1; nxt = 0; rq = "R8 BROM write"; end
                  default: begin cls = 3; wr = 0; nxt = 0; rq = "R5 class3 read"; end
               endcase
               k = (a + op + p) % 3;
               if (k > 0 && exp_honor(cls, wr)) rq = {rq, " R6 ext wait"};
               if (a < 4 || a > 18) rq = {rq, " R3 outside area"};
               run_cycle(a, wr, cls, nxt, bit'(op % 2), k, rq);
            end
         end
         for (int a = 4; a <= 9; a++) begin
            gap_pair(a, 1'b0);
            gap_pair(a, 1'b1);
         end
      end

      // R2: hot reset mid-cycle
      @(negedge clk);
      req = 1'b1;
      req_area = 5'd7;
      req_write = 1'b0;
      req_class = 2'd0;
      req_burst_next = 1'b0;
      ext_wait_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 strobe active before hot reset", int'(rd_n), 0);
      hot_rst_n = 1'b0;
      req = 1'b0;
      #1;
      check_idle("R2 during hot reset");
      @(negedge clk);
      hot_rst_n = 1'b1;
      for (int r = 0; r < 6; r++) rd_chk(r, "R2 kept after hot reset");
      run_cycle(11, 1'b1, 0, 1'b0, 1'b0, 1, "R2 cycle after hot reset R6");

      // cold reset restores defaults
      @(negedge clk);
      cold_rst_n = 1'b0;
      set_defaults();
      #1;
      check_idle("R1 second cold reset");
      for (int r = 0; r < 6; r++) rd_chk(r, "R1 defaults restored");
      @(negedge clk);
      cold_rst_n = 1'b1;
      run_cycle(17, 1'b0, 2, 1'b0, 1'b0, 0, "R1 default BROM first R8");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule